// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block derives a reference clock from one of several tick sources that all live in one system clock domain. Each source is a one-cycle enable pulse that stands for one edge of an input clock. The selected stream is divided by twice a divisor made of a 15-bit integer part and a 9-bit fraction counted in 1/512 steps. This gives an output rate of `fin * 256 / (512 * div + trim)`.

Software programs the block through a small word-wide register port. A control word holds the run and output-enable bits, the source select, the switch request, a read-only active flag and the integer divisor. A second word holds the fraction. Divisor writes go to shadow fields. They reach the running divider only after software raises the switch request. Hardware then drops the request when the transfer is done.

The output is a level `ref_lvl_o` plus a one-cycle pulse `ref_rise_o` on each output rising edge. Both are gated by output enable.

Top module: `refclk_frac_div`

## Requirements
- R1: After reset both register words read zero, the divider is off and both outputs are low.
- R2: Run mode with a nonzero active integer divisor N and a zero fraction: every output half-period lasts exactly N selected ticks, so `ref_rise_o` pulses once per 2N ticks.
- R3: A nonzero active fraction T is added to a 9-bit accumulator at each half-period end. The next half-period lasts N+1 ticks when that sum reaches 512, and N ticks otherwise, so the average half-period is N + T/512.
- R4: When the active integer divisor is zero the fraction is ignored. In that case each selected tick gives a one-cycle high on `ref_lvl_o` and a pulse on `ref_rise_o` in the following cycle.
- R5: Writes to the divisor (bits 30:16 of the control word) and to the fraction (bits 31:23 of the trim word) leave the running output unchanged until a switch request moves them to the divider.
- R6: Software sets the switch request by writing 1 to bit 9 of the control word. The transfer happens on the next output edge while running, or in the next cycle while the divider is off. Bit 9 reads 0 from the cycle after the transfer.
- R7: If a control write sets bit 9 in the same cycle as a transfer, the request stays set, and the new shadow values move to the divider at a later transfer.
- R8: While the active flag (bit 8) is set, writes to the source select (bits 3:0) are ignored. The other control fields are still written.
- R9: Active rises in the cycle after the first selected tick seen with the run bit (bit 15) set. It falls one cycle after the run bit is cleared. While the run bit is clear the divider is held idle and gives no rising pulse.
- R10: With output enable (bit 12) clear, both outputs stay low, while the divider and the active flag keep running.
- R11: Only ticks of the selected source advance the divider. A select value of NUM_SRC or above selects no source.
- R12: The control word carries select at bits 3:0, active at 8, request at 9, output enable at 12, run at 15 and the divisor at 30:16. The trim word carries the fraction at 31:23. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | NUM_SRC | One-cycle tick enables, one per clock source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Word select: 0 control word, 1 trim word |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the word chosen by reg_addr_i |
| ref_lvl_o | output | 1 | Divided output level, gated by output enable |
| ref_rise_o | output | 1 | One-cycle pulse on each output rising edge, gated by output enable |

## Verification
Two things can land on the request flag in one cycle: the software set through a control write and the hardware clear that comes with a transfer. The bench forces this with two control writes in a row, both setting the request, while the divider is off. The second write then lines up with the transfer started by the first. The flag must read 1 after that cycle and 0 one cycle later. A second overlap comes from a select write that arrives while the active flag is set: the read-back must keep the old source while the other fields change. A behavioural model, run every clock, also judges the accumulator-driven half-period lengths under regular and irregular tick streams.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int REG_W    = 32;
  localparam int SEL_W    = 4;
  localparam int SEL_LSB  = 0;
  localparam int ACT_BIT  = 8;
  localparam int REQ_BIT  = 9;
  localparam int OE_BIT   = 12;
  localparam int ON_BIT   = 15;
  localparam int DIV_W    = 15;
  localparam int DIV_LSB  = 16;
  localparam int TRIM_W   = 9;
  localparam int TRIM_LSB = 23;

  typedef struct packed {
    logic              on;
    logic              oe;
    logic              req;
    logic [SEL_W-1:0]  sel;
    logic [DIV_W-1:0]  div;
    logic [TRIM_W-1:0] trim;
  } ctrl_t;
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
  import refclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             active_i,
  input  logic             xfer_i,
  output ctrl_t            ctrl_o,
  output logic [REG_W-1:0] rdata_o
);
  ctrl_t ctrl_q;
  logic  wr_ctl, wr_trim;

  assign wr_ctl  = we_i && !addr_i;
  assign wr_trim = we_i && addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      // set by software wins over the transfer clear
      ctrl_q.req <= (ctrl_q.req && !xfer_i) || (wr_ctl && wdata_i[REQ_BIT]);
      if (wr_ctl) begin
        ctrl_q.on  <= wdata_i[ON_BIT];
        ctrl_q.oe  <= wdata_i[OE_BIT];
        ctrl_q.div <= wdata_i[DIV_LSB +: DIV_W];
        if (!active_i) ctrl_q.sel <= wdata_i[SEL_LSB +: SEL_W];
      end
      if (wr_trim) ctrl_q.trim <= wdata_i[TRIM_LSB +: TRIM_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i) begin
      rdata_o[TRIM_LSB +: TRIM_W] = ctrl_q.trim;
    end else begin
      rdata_o[SEL_LSB +: SEL_W] = ctrl_q.sel;
      rdata_o[ACT_BIT]          = active_i;
      rdata_o[REQ_BIT]          = ctrl_q.req;
      rdata_o[OE_BIT]           = ctrl_q.oe;
      rdata_o[ON_BIT]           = ctrl_q.on;
      rdata_o[DIV_LSB +: DIV_W] = ctrl_q.div;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/refclk_src_mux.sv
module refclk_src_mux
  import refclk_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tick_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = src_i[g] && (sel_i == SEL_W'(g));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/refclk_div_core.sv
module refclk_div_core
  import refclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              on_i,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic [DIV_W-1:0]  div_sh_i,
  input  logic [TRIM_W-1:0] trim_sh_i,
  output logic              xfer_o,
  output logic              active_o,
  output logic              lvl_o,
  output logic              rise_o
);
  logic [DIV_W-1:0]  act_div_q, cnt_q;
  logic [TRIM_W-1:0] act_trim_q, acc_q;
  logic              extra_q, lvl_q, rise_q, active_q;
  logic              bypass, hp_end, edge_hit;
  logic [DIV_W:0]    hp_len, cnt_nx;
  logic [TRIM_W:0]   acc_sum;

  assign bypass   = (act_div_q == '0);
  assign hp_len   = {1'b0, act_div_q} + {{DIV_W{1'b0}}, extra_q};
  assign cnt_nx   = {1'b0, cnt_q} + (DIV_W+1)'(1);
  assign hp_end   = (cnt_nx == hp_len);
  assign acc_sum  = {1'b0, acc_q} + {1'b0, act_trim_q};
  assign edge_hit = on_i && tick_i && (bypass || hp_end);
  assign xfer_o   = req_i && (!on_i || edge_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_div_q  <= '0;
      act_trim_q <= '0;
      cnt_q      <= '0;
      acc_q      <= '0;
      extra_q    <= 1'b0;
      lvl_q      <= 1'b0;
      rise_q     <= 1'b0;
      active_q   <= 1'b0;
    end else begin
      active_q <= on_i && (active_q || tick_i);
      if (!on_i) begin
        cnt_q   <= '0;
        acc_q   <= '0;
        extra_q <= 1'b0;
        lvl_q   <= 1'b0;
        rise_q  <= 1'b0;
      end else if (tick_i) begin
        if (bypass) begin
          lvl_q   <= 1'b1;
          rise_q  <= 1'b1;
          cnt_q   <= '0;
          acc_q   <= '0;
          extra_q <= 1'b0;
        end else if (hp_end) begin
          cnt_q   <= '0;
          lvl_q   <= !lvl_q;
          rise_q  <= !lvl_q;
          extra_q <= acc_sum[TRIM_W];
          acc_q   <= acc_sum[TRIM_W-1:0];
        end else begin
          cnt_q  <= cnt_nx[DIV_W-1:0];
          rise_q <= 1'b0;
        end
      end else begin
        rise_q <= 1'b0;
        if (bypass) lvl_q <= 1'b0;
      end
      // new divisor restarts the fraction phase
      if (xfer_o) begin
        act_div_q  <= div_sh_i;
        act_trim_q <= trim_sh_i;
        acc_q      <= '0;
        extra_q    <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign lvl_o    = lvl_q;
  assign rise_o   = rise_q;
endmodule

// File: rtl/refclk_frac_div.sv
module refclk_frac_div
  import refclk_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic               reg_we_i,
  input  logic               reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               ref_lvl_o,
  output logic               ref_rise_o
);
  ctrl_t ctrl;
  logic  tick, xfer, active, lvl, rise;

  refclk_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .active_i (active),
    .xfer_i   (xfer),
    .ctrl_o   (ctrl),
    .rdata_o  (reg_rdata_o)
  );

  refclk_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
    .src_i  (src_tick_i),
    .sel_i  (ctrl.sel),
    .tick_o (tick)
  );

  refclk_div_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .on_i      (ctrl.on),
    .tick_i    (tick),
    .req_i     (ctrl.req),
    .div_sh_i  (ctrl.div),
    .trim_sh_i (ctrl.trim),
    .xfer_o    (xfer),
    .active_o  (active),
    .lvl_o     (lvl),
    .rise_o    (rise)
  );

  assign ref_lvl_o  = lvl && ctrl.oe;
  assign ref_rise_o = rise && ctrl.oe;
endmodule

// File: rtl/refclk_frac_div_chk.sv
module refclk_frac_div_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       on_i,
  input logic       act_i,
  input logic [3:0] sel_i,
  input logic       req_i,
  input logic       xfer_i,
  input logic       wr_req_i,
  input logic       rise_i
);
  // R9
  off_clears_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_i |=> !act_i);
  // R9
  off_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_i |=> !rise_i);
  // R8
  sel_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> $stable(sel_i));
  // R6
  req_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !wr_req_i) |=> !req_i);
  // R7
  req_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && wr_req_i) |=> req_i);
endmodule

bind refclk_frac_div refclk_frac_div_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .on_i     (ctrl.on),
  .act_i    (active),
  .sel_i    (ctrl.sel),
  .req_i    (ctrl.req),
  .xfer_i   (xfer),
  .wr_req_i (reg_we_i && !reg_addr_i && reg_wdata_i[9]),
  .rise_i   (ref_rise_o)
);

// File: tb/refclk_frac_div_tb_top.sv
`timescale 1ns/1ps
module refclk_frac_div_tb_top;
  localparam int NSRC = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NSRC-1:0] src_tick_i = '0;
  logic            reg_we_i = 1'b0;
  logic            reg_addr_i = 1'b0;
  logic [31:0]     reg_wdata_i = '0;
  logic [31:0]     reg_rdata_o;
  logic            ref_lvl_o, ref_rise_o;

  int n_chk = 0, n_fail = 0, cyc_n = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  refclk_frac_div #(.NUM_SRC(NSRC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_tick_i(src_tick_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .ref_lvl_o(ref_lvl_o), .ref_rise_o(ref_rise_o)
  );

  // behavioural reference model
  int m_on, m_oe, m_req, m_sel, m_div, m_trim, m_act;
  int m_adiv, m_atrim, m_cnt, m_acc, m_extra, m_lvl, m_rise;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_on = 0; m_oe = 0; m_req = 0; m_sel = 0; m_div = 0; m_trim = 0; m_act = 0;
      m_adiv = 0; m_atrim = 0; m_cnt = 0; m_acc = 0; m_extra = 0; m_lvl = 0; m_rise = 0;
    end else begin
      int tk, byp, hend, edg, xf, sum, wc, wt;
      tk   = (m_sel < NSRC) ? int'(src_tick_i[m_sel]) : 0;
      wc   = int'(reg_we_i && !reg_addr_i);
      wt   = int'(reg_we_i && reg_addr_i);
      byp  = (m_adiv == 0);
      hend = ((m_cnt + 1) == (m_adiv + m_extra));
      edg  = m_on && tk && (byp || hend);
      xf   = m_req && (!m_on || edg);
      sum  = m_acc + m_atrim;
      if (!m_on) begin
        m_cnt = 0; m_acc = 0; m_extra = 0; m_lvl = 0; m_rise = 0;
      end else if (tk) begin
        if (byp) begin
          m_lvl = 1; m_rise = 1; m_cnt = 0; m_acc = 0; m_extra = 0;
        end else if (hend) begin
          m_cnt = 0; m_rise = !m_lvl; m_lvl = !m_lvl;
          m_extra = (sum >= 512); m_acc = sum % 512;
        end else begin
          m_cnt = m_cnt + 1; m_rise = 0;
        end
      end else begin
        m_rise = 0;
        if (byp) m_lvl = 0;
      end
      if (xf) begin
        m_adiv = m_div; m_atrim = m_trim; m_acc = 0; m_extra = 0;
      end
      m_req = (m_req && !xf) || (wc && reg_wdata_i[9]);
      if (wc) begin
        m_on = reg_wdata_i[15]; m_oe = reg_wdata_i[12]; m_div = int'(reg_wdata_i[30:16]);
        if (!m_act) m_sel = int'(reg_wdata_i[3:0]);
      end
      if (wt) m_trim = int'(reg_wdata_i[31:23]);
      m_act = m_on_prev_act(tk);
    end
  end

  // active uses the run bit as it was before this edge
  int m_on_d = 0;
  function automatic int m_on_prev_act(int tk);
    return (m_on_d != 0) && ((m_act != 0) || (tk != 0));
  endfunction
  always @(negedge clk_i) m_on_d = m_on;

  function automatic logic [31:0] m_rd(logic a);
    logic [31:0] r = '0;
    if (a) r[31:23] = 9'(m_trim);
    else begin
      r[3:0] = 4'(m_sel); r[8] = m_act[0]; r[9] = m_req[0];
      r[12] = m_oe[0]; r[15] = m_on[0]; r[30:16] = 15'(m_div);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
    chk(ref_lvl_o == (m_lvl[0] && m_oe[0]), "R3 model lvl", ref_lvl_o, m_lvl[0] && m_oe[0]);
    chk(ref_rise_o == (m_rise[0] && m_oe[0]), "R2 model rise", ref_rise_o, m_rise[0] && m_oe[0]);
    chk(reg_rdata_o == m_rd(reg_addr_i), "R12 model rdata", reg_rdata_o, m_rd(reg_addr_i));
    cyc_n++;
    src_tick_i[0] = 1'b1;
    src_tick_i[1] = (cyc_n % 3 == 0);
    src_tick_i[2] = 1'b0;
    src_tick_i[3] = 1'($urandom % 2);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_we_i = 1'b0; reg_addr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o; reg_addr_i = 1'b0;
  endtask

  function automatic logic [31:0] mk(int dv, bit on, bit oe, bit rq, int sel);
    return (32'(dv) << 16) | (32'(on) << 15) | (32'(oe) << 12) | (32'(rq) << 9) | 32'(sel);
  endfunction

  task automatic count(input int n, output int r);
    r = 0;
    for (int i = 0; i < n; i++) begin cyc(); r += int'(ref_rise_o); end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    logic [31:0] d;
    int r;
    #9 rst_ni = 1'b1;
    // R1
    rd(1'b0, d); chk(d == 32'h0, "R1 ctrl after reset", d, 0);
    rd(1'b1, d); chk(d == 32'h0, "R1 trim after reset", d, 0);
    chk(!ref_lvl_o && !ref_rise_o, "R1 outputs after reset", {ref_lvl_o, ref_rise_o}, 0);
    run(3);
    // R12
    wr(1'b0, mk(5, 0, 0, 0, 3));
    rd(1'b0, d); chk(d == 32'h0005_0003, "R12 ctrl layout", d, 32'h0005_0003);
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, d); chk(d == 32'hFF80_0000, "R12 trim layout", d, 32'hFF80_0000);
    wr(1'b1, 32'h0);
    // R2: div 3, every-cycle source, period 6
    wr(1'b0, mk(3, 1, 1, 1, 0));
    run(20);
    count(600, r); chk(r >= 98 && r <= 102, "R2 rise count div3", r, 100);
    // R6
    rd(1'b0, d); chk(d[9] == 1'b0, "R6 request cleared", d[9], 0);
    // R3: div 2 trim 256, period 5
    wr(1'b1, 32'(256) << 23);
    wr(1'b0, mk(2, 1, 1, 1, 0));
    run(20);
    count(1000, r); chk(r >= 198 && r <= 202, "R3 rise count 2.5", r, 200);
    // R5: shadow write without request
    wr(1'b0, mk(7, 1, 1, 0, 0));
    run(10);
    count(1000, r); chk(r >= 198 && r <= 202, "R5 shadow not applied", r, 200);
    // R8
    wr(1'b0, mk(7, 1, 1, 0, 2));
    rd(1'b0, d); chk(d[3:0] == 4'd0 && d[8], "R8 select locked", d[8:0], 9'h100);
    // R10
    wr(1'b0, mk(7, 1, 0, 0, 0));
    r = 0;
    for (int i = 0; i < 500; i++) begin cyc(); r += int'(ref_rise_o || ref_lvl_o); end
    chk(r == 0, "R10 gated outputs", r, 0);
    rd(1'b0, d); chk(d[8] == 1'b1, "R10 active while gated", d[8], 1);
    // R9
    wr(1'b0, mk(7, 0, 1, 0, 0));
    cyc();
    rd(1'b0, d); chk(d[8] == 1'b0, "R9 active falls", d[8], 0);
    // R7: request set collides with transfer
    wr(1'b0, mk(0, 0, 1, 1, 0));
    wr(1'b0, mk(0, 0, 1, 1, 0));
    rd(1'b0, d); chk(d[9] == 1'b1, "R7 set wins", d[9], 1);
    cyc();
    rd(1'b0, d); chk(d[9] == 1'b0, "R7 later transfer clears", d[9], 0);
    // R4: bypass on source 1 (tick every third cycle), trim ignored
    wr(1'b0, mk(0, 1, 1, 1, 1));
    run(10);
    count(300, r); chk(r >= 98 && r <= 102, "R4 bypass rise count", r, 100);
    // R11: silent source, then out-of-range select
    wr(1'b0, mk(0, 0, 1, 0, 1));
    run(3);
    wr(1'b0, mk(0, 1, 1, 0, 2));
    count(200, r); chk(r == 0, "R11 silent source", r, 0);
    rd(1'b0, d); chk(d[8] == 1'b0, "R11 no active on silent source", d[8], 0);
    wr(1'b0, mk(0, 1, 1, 0, 5));
    count(200, r); chk(r == 0, "R11 select out of range", r, 0);
    rd(1'b0, d); chk(d[3:0] == 4'd5, "R11 select readback", d[3:0], 5);
    // R3: irregular source, div 4 trim 100
    wr(1'b0, mk(0, 0, 1, 0, 0));
    run(3);
    wr(1'b1, 32'(100) << 23);
    wr(1'b0, mk(4, 1, 1, 1, 3));
    run(2000);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule